// File: doc/BRIEF.md
# Windowed Threshold Monitor with Persistence

This block watches a stream of already-converted light samples. Each sample is 32 bits wide and carries a 2-bit channel tag for one of four colour channels. One channel, chosen by configuration, is compared against a low bound and a high bound. Each bound is stored in a compact 16-bit form: a 12-bit mantissa and a 4-bit exponent, with a fixed extra shift of eight.

A violation sets a flag only after a programmable number of consecutive violating samples. The flags either follow the latest decision or stay set until software reads the configuration register. An interrupt output is driven from the flags, or from sample arrival, and its active level can be programmed.

Registers are reached through a one-cycle write strobe, a one-cycle read strobe and a 2-bit address. Read data is combinational from the address. The register map is:

- Address 0: low bound (reset 0x0000).
- Address 1: high bound (reset 0xFFFF).
- Address 2: configuration, 8 bits.
- Address 3: status, read-only.

Top module: `threshold_watch`

## Requirements
- R1: After reset the registers read as follows: address 0 reads 0x0000, address 1 reads 0xFFFF, address 2 reads 0x0000 and address 3 reads 0x0000. With polarity 0 the interrupt output idles high.
- R2: A bound word has the exponent in bits 15:12 and the mantissa in bits 11:0. Its value is mantissa << (8 + exponent). A sample strictly below the low bound is a low violation, and a sample strictly above the high bound is a high violation. A sample equal to either bound lies inside the window.
- R3: Samples whose tag differs from the channel-select field (configuration bits 3:2) leave the low and high flags unchanged.
- R4: The fault-count field (configuration bits 1:0) sets how many consecutive violating selected samples are needed before a flag is set. Codes 0, 1, 2 and 3 need 1, 2, 4 and 8 samples.
- R5: A selected sample that is not a violation on one side restarts that side's consecutive count. Any register write also restarts both counts.
- R6: With the latch bit (configuration bit 4) at 0, each selected sample sets the flags to that sample's persistence decision.
- R7: With the latch bit at 1, a set flag stays set until a read strobe at address 2. That read clears both flags and the arrival bit from the next cycle on, unless a selected sample sets a flag again in the same cycle.
- R8: Configuration bit 5 selects the interrupt's active level: 1 means active high, 0 means active low.
- R9: The interrupt source field (configuration bits 7:6) picks what drives the interrupt:
  - Code 0: either threshold flag.
  - Code 1: an arrival bit set by any sample.
  - Code 3: an arrival bit set by a sample tagged 3.
  - Code 2: nothing.
- R10: The status register holds the low flag in bit 0, the high flag in bit 1 and the arrival bit in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample present this cycle |
| smp_chan | input | 2 | Channel tag of the sample |
| smp_data | input | 32 | Decoded sample value |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears state at address 2) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt output with programmable level |

## Verification
The comparison is tried with samples just below, exactly at and just above each bound. These values separate strict comparison from inclusive comparison, and they exercise the mantissa and exponent decode. Runs of violations are cut off one sample short of the fault count, and other runs are broken by an in-window sample. These runs tell a consecutive counter apart from a cumulative one, and they confirm each fault-count code. Samples on other channels are mixed in to show they are ignored. Mode switches show the following:
- Latched flags differ from following flags.
- Both interrupt levels are produced.
- Each interrupt source drives the output.

// File: rtl/threshold_watch.sv
module threshold_watch #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [1:0]        smp_chan,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq
);
  localparam int CMP_W  = (DATA_W > 35) ? DATA_W : 35;
  localparam int CNT_W  = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = 4'd8;

  logic [15:0] bound_lo, bound_hi;
  logic [7:0]  cfg;
  logic        flag_lo, flag_hi, arrived;
  logic [CNT_W-1:0] run_lo, run_hi;

  wire [1:0] fault_code = cfg[1:0];
  wire [1:0] chan_sel   = cfg[3:2];
  wire       latch_on   = cfg[4];
  wire       active_hi  = cfg[5];
  wire [1:0] irq_src    = cfg[7:6];

  wire [CMP_W-1:0] lim_lo = CMP_W'(bound_lo[11:0]) << (5'd8 + {1'b0, bound_lo[15:12]});
  wire [CMP_W-1:0] lim_hi = CMP_W'(bound_hi[11:0]) << (5'd8 + {1'b0, bound_hi[15:12]});
  wire [CMP_W-1:0] smp_ext = CMP_W'(smp_data);

  wire sel_hit = smp_valid && (smp_chan == chan_sel);
  wire viol_lo = smp_ext < lim_lo;
  wire viol_hi = smp_ext > lim_hi;

  wire [CNT_W-1:0] need = CNT_W'(1) << fault_code;
  wire [CNT_W-1:0] run_lo_nx = viol_lo ? ((run_lo == CNT_MAX) ? CNT_MAX : run_lo + 1'b1) : '0;
  wire [CNT_W-1:0] run_hi_nx = viol_hi ? ((run_hi == CNT_MAX) ? CNT_MAX : run_hi + 1'b1) : '0;
  wire hit_lo = viol_lo && (run_lo_nx >= need);
  wire hit_hi = viol_hi && (run_hi_nx >= need);

  wire rd_clr   = reg_rd && (reg_addr == 2'd2);
  wire cfg_wr   = reg_wr && (reg_addr != 2'd3);
  wire arr_set  = (irq_src == 2'd1) ? smp_valid :
                  (irq_src == 2'd3) ? (smp_valid && smp_chan == 2'd3) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_lo <= 16'h0000;
      bound_hi <= 16'hFFFF;
      cfg      <= 8'h00;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0: bound_lo <= reg_wdata;
        2'd1: bound_hi <= reg_wdata;
        2'd2: cfg      <= reg_wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_lo <= '0;
      run_hi <= '0;
    end else if (cfg_wr) begin
      run_lo <= '0;
      run_hi <= '0;
    end else if (sel_hit) begin
      run_lo <= run_lo_nx;
      run_hi <= run_hi_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo <= 1'b0;
      flag_hi <= 1'b0;
      arrived <= 1'b0;
    end else begin
      if (sel_hit && !latch_on) begin
        flag_lo <= hit_lo;
        flag_hi <= hit_hi;
      end else begin
        flag_lo <= (flag_lo && !rd_clr) || (sel_hit && hit_lo);
        flag_hi <= (flag_hi && !rd_clr) || (sel_hit && hit_hi);
      end
      arrived <= (arrived && !rd_clr) || arr_set;
    end
  end

  logic irq_act;
  always_comb begin
    case (irq_src)
      2'd0:    irq_act = flag_lo || flag_hi;
      2'd1,
      2'd3:    irq_act = arrived;
      default: irq_act = 1'b0;
    endcase
  end
  assign irq = active_hi ? irq_act : !irq_act;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = bound_lo;
      2'd1:    reg_rdata = bound_hi;
      2'd2:    reg_rdata = {8'h00, cfg};
      default: reg_rdata = {13'h0000, arrived, flag_hi, flag_lo};
    endcase
  end

  // R3
  foreign_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && smp_chan != chan_sel && !rd_clr) |=> ($stable(flag_lo) && $stable(flag_hi)));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_on && flag_lo && !rd_clr) |=> flag_lo);

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !smp_valid) |=> (!flag_lo && !flag_hi && !arrived));

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_lo) || $rose(flag_hi)) |-> $past(sel_hit));

  // R5
  run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_lo <= CNT_MAX) && (run_hi <= CNT_MAX));

  // R9
  arrive_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arrived) |-> $past(smp_valid));
endmodule

// File: tb/threshold_watch_tb_top.sv
`timescale 1ns/1ps
module threshold_watch_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [1:0] smp_chan = 2'd0;
  logic [31:0] smp_data = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd3;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] data;
    logic        irq_v;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  threshold_watch dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (reg_rdata !== e.data || irq !== e.irq_v) begin
        failures++;
        $display("FAIL %s rdata=%h exp=%h irq=%b exp=%b", e.tag, reg_rdata, e.data, irq, e.irq_v);
      end
    end
  end

  task automatic wreg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rdclr();
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd2;
    @(negedge clk); reg_rd = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic send(input logic [1:0] ch, input logic [31:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_chan = ch; smp_data = d;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic expect_reg(input logic [1:0] a, input logic [15:0] d, input logic iv, input string tag);
    exp_t e;
    #1;
    reg_addr = a;
    e.data = d; e.irq_v = iv; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    #1;
    reg_addr = 2'd3;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_reg(2'd0, 16'h0000, 1'b1, "R1 low bound reset");
    expect_reg(2'd1, 16'hFFFF, 1'b1, "R1 high bound reset");
    expect_reg(2'd2, 16'h0000, 1'b1, "R1 config reset");
    expect_reg(2'd3, 16'h0000, 1'b1, "R1 status reset");

    // low = 0x10 << 9 = 0x2000, high = 0x100 << 8 = 0x10000
    wreg(2'd0, 16'h1010);
    wreg(2'd1, 16'h0100);
    wreg(2'd2, 16'h0024);   // chan 1, active high, fault code 0
    send(2'd1, 32'h1FFF);
    expect_reg(2'd3, 16'h0001, 1'b1, "R2 below low bound");
    send(2'd1, 32'h2000);
    expect_reg(2'd3, 16'h0000, 1'b0, "R2 R6 equal to low bound");
    send(2'd0, 32'h0);
    expect_reg(2'd3, 16'h0000, 1'b0, "R3 other channel low value");
    send(2'd1, 32'h10001);
    expect_reg(2'd3, 16'h0002, 1'b1, "R2 R10 above high bound");
    send(2'd2, 32'h5000);
    expect_reg(2'd3, 16'h0002, 1'b1, "R3 other channel leaves flag");
    send(2'd1, 32'h10000);
    expect_reg(2'd3, 16'h0000, 1'b0, "R2 R6 equal to high bound");

    wreg(2'd2, 16'h0026);   // fault code 2: four samples
    for (int i = 0; i < 3; i++) send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0000, 1'b0, "R4 three of four");
    send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0001, 1'b1, "R4 four of four");
    send(2'd1, 32'h5000);
    expect_reg(2'd3, 16'h0000, 1'b0, "R6 inside window");
    for (int i = 0; i < 3; i++) send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0000, 1'b0, "R5 run restarted");
    send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0001, 1'b1, "R5 run completes");

    wreg(2'd2, 16'h0027);   // fault code 3: eight samples
    for (int i = 0; i < 7; i++) send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0000, 1'b0, "R4 seven of eight");
    send(2'd1, 32'h100);
    expect_reg(2'd3, 16'h0001, 1'b1, "R4 eight of eight");

    rdclr();
    expect_reg(2'd3, 16'h0000, 1'b0, "R7 read clears");
    wreg(2'd2, 16'h0034);   // latched, active high
    send(2'd1, 32'h20000);
    expect_reg(2'd3, 16'h0002, 1'b1, "R7 latched set");
    send(2'd1, 32'h5000);
    expect_reg(2'd3, 16'h0002, 1'b1, "R7 latched holds");
    rdclr();
    expect_reg(2'd3, 16'h0000, 1'b0, "R7 latched cleared");
    send(2'd1, 32'h20000);
    expect_reg(2'd3, 16'h0002, 1'b1, "R7 latched set again");

    wreg(2'd2, 16'h0014);   // active low
    expect_reg(2'd3, 16'h0002, 1'b0, "R8 active low asserted");
    rdclr();
    expect_reg(2'd3, 16'h0000, 1'b1, "R8 active low idle");

    wreg(2'd2, 16'h0064);   // source: any sample
    send(2'd3, 32'h5000);
    expect_reg(2'd3, 16'h0004, 1'b1, "R9 R10 any arrival");
    rdclr();
    expect_reg(2'd3, 16'h0000, 1'b0, "R9 arrival cleared");
    wreg(2'd2, 16'h00E4);   // source: channel 3 arrival
    send(2'd1, 32'h0);
    expect_reg(2'd3, 16'h0001, 1'b0, "R9 flag does not drive irq");
    send(2'd3, 32'h5000);
    expect_reg(2'd3, 16'h0005, 1'b1, "R9 last channel arrival");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule